// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block is the receive half of an asynchronous serial port. It samples an RX line on a 16× oversample tick and finds the start edge. Each bit is resolved by a majority vote, and 8 or 9 data bits are collected with the least significant bit first. Each finished character moves into a receive data register. A bank of status flags runs beside the data path. The flags report that a character is waiting, that the receiver is part-way through a frame, that the line has gone quiet, and four kinds of error: overrun, noise, framing or break, and parity.

Software, or a bus-side wrapper, reads status and data through two one-cycle read strobes. The flags are cleared in two ways. A data read alone clears the data-ready flag. A status read followed later by a data read also clears the error flags and the idle flag. Baud generation, transmission and interrupt logic live elsewhere.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, every flag output is 0 and `rdata` is 0.
- R2: A bit lasts 16 ticks. The bit value is the 2-of-3 majority of samples 7, 8 and 9, where sample 0 is the first low sample of the start bit. Data follows the start bit with the least significant bit first, so `rdata[0]` is the first data bit. `cfg_nine`=0 selects 8 data bits and `cfg_nine`=1 selects 9. A stop bit ends the frame.
- R3: `f_ready` goes to 1 when a finished character is written into `rdata`. A `rd_data` pulse clears it to 0.
- R4: `f_active` is 1 from the first low sample of a start bit until the stop bit is resolved, and 0 otherwise. A start bit that votes high is dropped: `f_active` returns to 0 and no character is delivered.
- R5: `f_idle` goes to 1 after the line stays high, with the receiver inactive, for one character time: 160 samples in 8-bit mode and 176 in 9-bit mode. The idle detector fires once and is re-armed only by a completed character, so it does not fire after reset until a character has arrived.
- R6: A character that completes while `f_ready` is 1, with no `rd_data` in the same cycle, sets `f_overrun`. In that case the character is discarded and `rdata`, `f_ready`, `f_noise`, `f_frame` and `f_parity` keep their values.
- R7: `f_noise` is loaded with 1 when any bit of the delivered frame, from start bit to stop bit, had samples 7, 8 and 9 not all equal.
- R8: `f_frame` is loaded with 1 when the stop bit votes low. This includes a break, where the whole frame is low.
- R9: When `cfg_par_en`=1, the last data bit is the parity bit and stays in `rdata`. `f_parity` is loaded with 1 when the number of ones among the received data bits is odd with `cfg_par_odd`=0 (even sense), or even with `cfg_par_odd`=1 (odd sense). When `cfg_par_en`=0, `f_parity` is loaded with 0.
- R10: In 9-bit mode `rdata[8]` holds the ninth data bit. In 8-bit mode `rdata[8]` reads 0.
- R11: A `rd_stat` pulse followed later by a `rd_data` pulse clears `f_overrun`, `f_noise`, `f_frame`, `f_parity` and `f_idle`. A `rd_data` pulse with no status read before it leaves those flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high, asynchronous |
| os_tick | input | 1 | One-cycle pulse at 16× the bit rate |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 makes the last data bit a checked parity bit |
| cfg_par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| rd_stat | input | 1 | One-cycle status-register read strobe |
| rd_data | input | 1 | One-cycle data-register read strobe |
| rdata | output | 9 | Receive data register |
| f_ready | output | 1 | New character waiting |
| f_active | output | 1 | Frame in progress |
| f_idle | output | 1 | Idle line detected |
| f_overrun | output | 1 | Character lost to a full register |
| f_noise | output | 1 | Sample disagreement in the delivered frame |
| f_frame | output | 1 | Stop bit low or break |
| f_parity | output | 1 | Parity mismatch |

## Verification
Some properties hold on every cycle, and the assertions check them there. Data-ready rises only on a character completion and falls after a data read unless a new character lands in the same cycle. An overrun is flagged whenever a character completes into a full register, and `rdata` does not move when that happens. The idle flag never rises during an active frame, and bit 8 of a character delivered in 8-bit mode is 0. Other behaviours depend on serial waveforms, so only the bench scenarios can show them. These are the bit order and the vote result, noise from one corrupted sample, parity under both senses, stop-bit and break framing, false-start rejection, the one-shot idle detector, and the two-step clearing sequence.

// File: rtl/serial_rx_pkg.sv
// Shared types for the serial receive path.
// Assumes characters are at most 9 data bits wide.
package serial_rx_pkg;

    localparam int CHAR_W = 9;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    // A finished character together with the error bits of its frame.
    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              noise;
        logic              frame_err;
        logic              par_err;
    } rx_char_t;

endpackage

// File: rtl/rx_bit_engine.sv
// Frame engine: detects the start bit, votes each bit from three mid-bit
// samples, shifts data in LSB first and reports a finished character with
// its noise, framing and parity results as a one-cycle pulse.
// Assumes rx is already synchronised and tick is a one-cycle pulse.
module rx_bit_engine
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rx,
    input  logic     nine,
    input  logic     par_en,
    input  logic     par_odd,
    output logic     busy,
    output logic     done,
    output rx_char_t char_out
);

    localparam int            CW   = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] V_LO = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] V_MD = CW'(OVERSAMPLE / 2);
    localparam logic [CW-1:0] V_HI = CW'(OVERSAMPLE / 2 + 1);
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    rx_state_t         state;
    logic [CW-1:0]     smp_cnt;
    logic [3:0]        bit_idx;
    logic              s_lo, s_md;
    logic [CHAR_W-1:0] shreg;
    logic              noise_acc;

    logic              vote, disagree;
    logic [3:0]        last_bit;
    logic [CHAR_W-1:0] aligned;

    // Majority vote and disagreement over the three mid-bit samples.
    always_comb begin
        vote     = (s_lo & s_md) | (s_lo & rx) | (s_md & rx);
        disagree = !((s_lo == s_md) && (s_md == rx));
        last_bit = nine ? 4'd8 : 4'd7;
        aligned  = nine ? shreg : {1'b0, shreg[CHAR_W-1:1]};
    end

    assign busy = (state != RX_IDLE);

    // Frame sequencing, sampling and character delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            smp_cnt   <= '0;
            bit_idx   <= '0;
            s_lo      <= 1'b1;
            s_md      <= 1'b1;
            shreg     <= '0;
            noise_acc <= 1'b0;
            done      <= 1'b0;
            char_out  <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == RX_IDLE) begin
                    if (!rx) begin
                        state     <= RX_START;
                        smp_cnt   <= CW'(1);
                        noise_acc <= 1'b0;
                    end
                end else begin
                    smp_cnt <= (smp_cnt == LAST) ? '0 : smp_cnt + 1'b1;
                    if (smp_cnt == V_LO) s_lo <= rx;
                    if (smp_cnt == V_MD) s_md <= rx;
                    if (smp_cnt == V_HI) begin
                        noise_acc <= noise_acc | disagree;
                        case (state)
                            RX_START: if (vote) state <= RX_IDLE;
                            RX_DATA:  shreg <= {vote, shreg[CHAR_W-1:1]};
                            RX_STOP: begin
                                state              <= RX_IDLE;
                                done               <= 1'b1;
                                char_out.data      <= aligned;
                                char_out.noise     <= noise_acc | disagree;
                                char_out.frame_err <= !vote;
                                char_out.par_err   <= par_en & ((^aligned) ^ par_odd);
                            end
                            default: ;
                        endcase
                    end
                    if (smp_cnt == LAST) begin
                        if (state == RX_START) begin
                            state   <= RX_DATA;
                            bit_idx <= '0;
                        end else if (state == RX_DATA) begin
                            if (bit_idx == last_bit) state <= RX_STOP;
                            else                     bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rx_idle_watch.sv
// Idle-line detector: counts consecutive high samples while no frame is
// in progress and pulses once when one character time has elapsed.
// Assumes it is re-armed only by char_done; starts disarmed after reset.
module rx_idle_watch #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx,
    input  logic busy,
    input  logic nine,
    input  logic char_done,
    output logic idle_hit
);

    localparam int           LIM8 = OVERSAMPLE * 10;
    localparam int           LIM9 = OVERSAMPLE * 11;
    localparam int           QW   = $clog2(LIM9 + 1);
    localparam logic [QW-1:0] L8  = QW'(LIM8);
    localparam logic [QW-1:0] L9  = QW'(LIM9);

    logic [QW-1:0] quiet_cnt;
    logic [QW-1:0] limit;
    logic          armed;

    assign limit = nine ? L9 : L8;

    // Count high samples, saturate, fire once per arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
            armed     <= 1'b0;
            idle_hit  <= 1'b0;
        end else begin
            idle_hit <= 1'b0;
            if (tick) begin
                if (rx && !busy) begin
                    if (quiet_cnt < limit) quiet_cnt <= quiet_cnt + 1'b1;
                    if ((quiet_cnt == limit - 1'b1) && armed) begin
                        idle_hit <= 1'b1;
                        armed    <= 1'b0;
                    end
                end else begin
                    quiet_cnt <= '0;
                end
            end
            if (char_done) armed <= 1'b1;
        end
    end

endmodule

// File: rtl/rx_flag_bank.sv
// Receive data register and status flags. Applies the overrun rule
// (keep the buffered character) and the two-step clearing sequence.
// Assumes done and idle_hit are one-cycle pulses.
module rx_flag_bank
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  rx_char_t          char_in,
    input  logic              idle_hit,
    input  logic              rd_stat,
    input  logic              rd_data,
    output logic [CHAR_W-1:0] rdata,
    output logic              f_ready,
    output logic              f_idle,
    output logic              f_overrun,
    output logic              f_noise,
    output logic              f_frame,
    output logic              f_parity
);

    logic stat_seen;
    logic clear_err;
    logic still_full;

    assign clear_err  = rd_data && stat_seen;
    assign still_full = f_ready && !rd_data;

    // Flag updates: clears first, then new events override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            f_ready   <= 1'b0;
            f_idle    <= 1'b0;
            f_overrun <= 1'b0;
            f_noise   <= 1'b0;
            f_frame   <= 1'b0;
            f_parity  <= 1'b0;
            stat_seen <= 1'b0;
        end else begin
            if (rd_stat) stat_seen <= 1'b1;
            if (rd_data) begin
                stat_seen <= 1'b0;
                f_ready   <= 1'b0;
            end
            if (clear_err) begin
                f_overrun <= 1'b0;
                f_noise   <= 1'b0;
                f_frame   <= 1'b0;
                f_parity  <= 1'b0;
                f_idle    <= 1'b0;
            end
            if (idle_hit) f_idle <= 1'b1;
            if (done) begin
                if (still_full) begin
                    f_overrun <= 1'b1;
                end else begin
                    rdata    <= char_in.data;
                    f_ready  <= 1'b1;
                    f_noise  <= char_in.noise;
                    f_frame  <= char_in.frame_err;
                    f_parity <= char_in.par_err;
                end
            end
        end
    end

endmodule

// File: rtl/serial_rx_unit.sv
// Top of the serial receive path: input synchroniser, frame engine,
// idle detector and flag bank. Assumes os_tick runs at OVERSAMPLE times
// the bit rate and that configuration changes only while idle.
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_in,
    input  logic       os_tick,
    input  logic       cfg_nine,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rd_stat,
    input  logic       rd_data,
    output logic [8:0] rdata,
    output logic       f_ready,
    output logic       f_active,
    output logic       f_idle,
    output logic       f_overrun,
    output logic       f_noise,
    output logic       f_frame,
    output logic       f_parity
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    logic                   busy;
    logic                   char_done;
    logic                   idle_hit;
    rx_char_t               char_bus;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            // Single-stage capture of the line, idle value high.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= 1'b1;
                else        sync_q <= rx_in;
            end
        end else begin : g_syncn
            // Multi-stage synchroniser chain, idle value high.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
            end
        end
    endgenerate

    assign rx_s     = sync_q[SYNC_STAGES-1];
    assign f_active = busy;

    rx_bit_engine #(.OVERSAMPLE(OVERSAMPLE)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .rx       (rx_s),
        .nine     (cfg_nine),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .busy     (busy),
        .done     (char_done),
        .char_out (char_bus)
    );

    rx_idle_watch #(.OVERSAMPLE(OVERSAMPLE)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .rx        (rx_s),
        .busy      (busy),
        .nine      (cfg_nine),
        .char_done (char_done),
        .idle_hit  (idle_hit)
    );

    rx_flag_bank u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (char_done),
        .char_in   (char_bus),
        .idle_hit  (idle_hit),
        .rd_stat   (rd_stat),
        .rd_data   (rd_data),
        .rdata     (rdata),
        .f_ready   (f_ready),
        .f_idle    (f_idle),
        .f_overrun (f_overrun),
        .f_noise   (f_noise),
        .f_frame   (f_frame),
        .f_parity  (f_parity)
    );

endmodule

// File: rtl/serial_rx_unit_chk.sv
// Property checker for serial_rx_unit, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module serial_rx_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_data,
    input logic       cfg_nine,
    input logic [8:0] rdata,
    input logic       f_ready,
    input logic       f_active,
    input logic       f_idle,
    input logic       f_overrun,
    input logic       char_done
);

    // R3
    ready_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_ready) |-> $past(char_done));

    // R3
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !char_done) |=> !f_ready);

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && f_ready && !rd_data) |=> f_overrun);

    // R6
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_overrun) |-> (rdata == $past(rdata)));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_idle) |-> !$past(f_active));

    // R10
    narrow_bit8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(f_ready) && !$past(cfg_nine)) |-> (rdata[8] == 1'b0));

endmodule

bind serial_rx_unit serial_rx_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_data   (rd_data),
    .cfg_nine  (cfg_nine),
    .rdata     (rdata),
    .f_ready   (f_ready),
    .f_active  (f_active),
    .f_idle    (f_idle),
    .f_overrun (f_overrun),
    .char_done (char_done)
);

// File: tb/serial_rx_unit_bench.sv
// Self-checking bench: a vector table of frames walked by one loop, then
// directed tests for reset, idle, overrun, clearing and false starts.
module serial_rx_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       os_tick;
    logic       cfg_nine = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rd_stat = 1'b0;
    logic       rd_data = 1'b0;
    logic [8:0] rdata;
    logic       f_ready, f_active, f_idle, f_overrun, f_noise, f_frame, f_parity;

    int checks = 0;
    int errors = 0;

    logic [1:0] tcnt = 2'd0;

    always #4 clk = ~clk;

    // Oversample tick every fourth clock.
    always_ff @(posedge clk) tcnt <= tcnt + 2'd1;
    assign os_tick = (tcnt == 2'd3);

    serial_rx_unit u_serial_rx_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_in       (rx_in),
        .os_tick     (os_tick),
        .cfg_nine    (cfg_nine),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .rd_stat     (rd_stat),
        .rd_data     (rd_data),
        .rdata       (rdata),
        .f_ready     (f_ready),
        .f_active    (f_active),
        .f_idle      (f_idle),
        .f_overrun   (f_overrun),
        .f_noise     (f_noise),
        .f_frame     (f_frame),
        .f_parity    (f_parity)
    );

    typedef struct packed {
        logic       nine;
        logic       pen;
        logic       podd;
        logic [8:0] bits;
        logic       stop;
        logic       glitch;
        logic [8:0] exp_data;
        logic       exp_n;
        logic       exp_f;
        logic       exp_p;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 9'h0A5, 1'b1, 1'b0, 9'h0A5, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 9'h000, 1'b1, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b0, 9'h1C3, 1'b1, 1'b0, 9'h1C3, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 9'h003, 1'b1, 1'b0, 9'h003, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 9'h007, 1'b1, 1'b0, 9'h007, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b1, 1'b1, 9'h007, 1'b1, 1'b0, 9'h007, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b1, 9'h100, 1'b1, 1'b0, 9'h100, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 1'b0, 9'h000, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b0, 9'h03C, 1'b1, 1'b1, 9'h03C, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 9'h1FF, 1'b1, 1'b0, 9'h0FF, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 9'h1FF, 1'b1, 1'b0, 9'h1FF, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Hold the line for one oversample period (4 clocks).
    task automatic slot(input logic v);
        rx_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic idle_slots(input int n);
        for (int i = 0; i < n; i++) slot(1'b1);
    endtask

    // Start bit, data LSB first (optional glitch on data bit 2, sample 8), stop.
    task automatic send(input logic nine, input logic [8:0] bits,
                        input logic stop, input logic glitch);
        for (int s = 0; s < 16; s++) slot(1'b0);
        for (int b = 0; b < (nine ? 9 : 8); b++)
            for (int s = 0; s < 16; s++)
                slot((glitch && b == 2 && s == 8) ? ~bits[b] : bits[b]);
        for (int s = 0; s < 16; s++) slot(stop);
    endtask

    task automatic read_stat;
        rd_stat = 1'b1;
        @(negedge clk);
        rd_stat = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_data;
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 rdata", rdata, 9'h000);
        check("R1 flags", {2'b00, f_ready, f_active, f_idle, f_overrun, f_noise, f_frame, f_parity}, 9'h000);
        rst_n = 1'b1;
        idle_slots(4);

        // Vector table: R2 R3 R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            cfg_nine    = VECS[i].nine;
            cfg_par_en  = VECS[i].pen;
            cfg_par_odd = VECS[i].podd;
            send(VECS[i].nine, VECS[i].bits, VECS[i].stop, VECS[i].glitch);
            idle_slots(20);
            check($sformatf("R2 R10 data vec %0d", i), rdata, VECS[i].exp_data);
            check($sformatf("R3 ready vec %0d", i), {8'd0, f_ready}, 9'd1);
            check($sformatf("R7 noise vec %0d", i), {8'd0, f_noise}, {8'd0, VECS[i].exp_n});
            check($sformatf("R8 frame vec %0d", i), {8'd0, f_frame}, {8'd0, VECS[i].exp_f});
            check($sformatf("R9 parity vec %0d", i), {8'd0, f_parity}, {8'd0, VECS[i].exp_p});
            read_stat();
            read_data();
            check($sformatf("R11 cleared vec %0d", i),
                  {4'd0, f_ready, f_overrun, f_noise, f_frame, f_parity}, 9'd0);
        end
        cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

        // R5: one-shot idle after a character, not re-armed by quiet time
        idle_slots(200);
        check("R5 idle set", {8'd0, f_idle}, 9'd1);
        read_stat();
        read_data();
        check("R11 idle cleared", {8'd0, f_idle}, 9'd0);
        idle_slots(200);
        check("R5 idle not rearmed", {8'd0, f_idle}, 9'd0);

        // R4: active mid-frame, data 0xFE via start+bit0 low then high
        for (int s = 0; s < 20; s++) slot(1'b0);
        check("R4 active mid frame", {8'd0, f_active}, 9'd1);
        for (int s = 0; s < 12; s++) slot(1'b0);
        for (int s = 0; s < 128; s++) slot(1'b1);
        idle_slots(8);
        check("R4 active after frame", {8'd0, f_active}, 9'd0);
        check("R2 data 0xFE", rdata, 9'h0FE);
        read_data();

        // R4: false start rejected
        for (int s = 0; s < 4; s++) slot(1'b0);
        idle_slots(40);
        check("R4 false start no ready", {8'd0, f_ready}, 9'd0);
        check("R4 false start inactive", {8'd0, f_active}, 9'd0);

        // R6: overrun keeps first character
        send(1'b0, 9'h011, 1'b1, 1'b0);
        idle_slots(8);
        send(1'b0, 9'h022, 1'b1, 1'b0);
        idle_slots(8);
        check("R6 overrun set", {8'd0, f_overrun}, 9'd1);
        check("R6 data kept", rdata, 9'h011);
        check("R6 ready kept", {8'd0, f_ready}, 9'd1);

        // R11: data read alone leaves error flags
        read_data();
        check("R3 ready cleared", {8'd0, f_ready}, 9'd0);
        check("R11 overrun held", {8'd0, f_overrun}, 9'd1);
        read_stat();
        read_data();
        check("R11 overrun cleared", {8'd0, f_overrun}, 9'd0);

        // R1: reset mid-operation restores reset state
        send(1'b0, 9'h0AA, 1'b0, 1'b0);
        idle_slots(8);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset again", {f_ready, f_active, f_idle, f_overrun, f_noise, f_frame, f_parity, 2'b00}, 9'd0);
        check("R1 rdata again", rdata, 9'h000);

        finish_run();
    end

endmodule